// File: doc/BRIEF.md
# Bidirectional GPIO Port with Prioritised Takeover

This block is an 8-bit general-purpose I/O port slice. Software controls it through a small register bus with three addresses: a per-pin direction register, an output latch register, and a pin-level read path. Every pin has its own output enable and output level for a tri-state pad. Pad inputs pass through a two-flop synchroniser before any logic sees them.

Three higher-priority functions can take pins away from plain GPIO use. An external multiplexed address/data bus can claim all eight pins. A parallel-slave control mode turns pins 0, 1 and 2 into read, write and chip-select strobe inputs. A configuration input hands pin 7 to an alternate capture/compare/PWM peripheral. The bus controller, the slave port and the peripheral are outside the block; only their interface signals appear here.

The priority from highest to lowest is external bus, then slave-port strobes, then alternate pin, then GPIO. Register writes are always accepted, even while a takeover is active, and take effect on the pads once the takeover ends.

Top module: `gpio_port_ovr`

## Requirements
- R1: Synchronous active-high reset sets the direction register to 8'hFF (all inputs), the output latch to 8'h00 and the synchroniser to 8'h00, so with no takeover active every `pad_oe` bit is 0.
- R2: With no takeover, a direction bit of 0 sets that pin's `pad_oe` to 1 and its `pad_out` to the latch bit; a direction bit of 1 clears that pin's `pad_oe`.
- R3: A read of address 1 (latch) returns the stored latch value, not the pin level.
- R4: A write to address 0 (port) updates the output latch exactly as a write to address 1 does; a write to address 2 loads the direction register.
- R5: A read of address 0 returns the pad levels delayed by two clock edges, whatever the direction bits hold.
- R6: When `xbus_disable` is 0, all eight pads take `pad_out = xbus_ad_out` and `pad_oe = {8{xbus_ad_oe}}`, overriding direction, slave-port and alternate-pin settings; `xbus_ad_in` then carries the synchronised pins, and is 0 otherwise.
- R7: When `xbus_disable` is 1 and `psp_mode` is 1, pins 0, 1, 2 have `pad_oe` 0 and `psp_rd_n`, `psp_wr_n`, `psp_cs_n` carry synchronised pins 0, 1, 2; otherwise all three strobes are 1.
- R8: When `xbus_disable` is 1 and `alt_sel_n` is 0, pin 7 takes `pad_out = alt_out`, `pad_oe = alt_oe` and `alt_in` carries synchronised pin 7; otherwise `alt_in` is 0. Slave-port mode does not touch pin 7.
- R9: Address 3 reads as 8'h00 and a write to it changes neither register.
- R10: Register writes made while the external bus owns the port are kept and drive the pads once `xbus_disable` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 unused |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables (1 drives) |
| xbus_disable | input | 1 | 1 frees the port from the external bus |
| xbus_ad_out | input | 8 | External bus high address/data byte to drive |
| xbus_ad_oe | input | 1 | External bus drive enable |
| xbus_ad_in | output | 8 | Synchronised pins toward the bus controller |
| psp_mode | input | 1 | Slave-port strobe mode on pins 0..2 |
| psp_rd_n | output | 1 | Read strobe from pin 0 |
| psp_wr_n | output | 1 | Write strobe from pin 1 |
| psp_cs_n | output | 1 | Chip select from pin 2 |
| alt_sel_n | input | 1 | 0 routes pin 7 to the alternate peripheral |
| alt_out | input | 1 | Peripheral output level for pin 7 |
| alt_oe | input | 1 | Peripheral drive enable for pin 7 |
| alt_in | output | 1 | Synchronised pin 7 toward the peripheral |

## Verification
The direction register is swept over all 256 values against a fixed latch pattern, which separates pins that must drive the latch from pins that must float. Every pad value is applied in turn and read back one and two edges later, telling the correct synchroniser latency apart from a shorter or longer one, and every port-address write value is read back from the latch address. All eight combinations of the three takeover controls are crossed with both external-bus and peripheral drive enables, so a wrong priority or a missing pin-range limit shows up as a mismatched enable or strobe on a specific pin.

// File: rtl/gpio_ovr_pkg.sv
`timescale 1ns/1ps
package gpio_ovr_pkg;

    localparam int PORT_W     = 8;
    localparam int SYNC_DEPTH = 2;
    localparam int CTL_PINS   = 3;
    localparam int ALT_IDX    = 7;
    localparam int ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PIN   = 2'd0,
        REG_LATCH = 2'd1,
        REG_DIR   = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OWN_GPIO = 2'd0,
        OWN_XBUS = 2'd1,
        OWN_PSP  = 2'd2,
        OWN_ALT  = 2'd3
    } pin_owner_e;

    typedef struct packed {
        logic drive;
        logic level;
    } pad_ctl_t;

    typedef struct packed {
        logic xbus_on;
        logic psp_on;
        logic alt_on;
    } takeover_t;

    // Priority: external bus, then slave strobes, then alternate pin, then GPIO.
    function automatic pin_owner_e owner_of(takeover_t tk, int idx, int ctl_pins, int alt_idx);
        if (tk.xbus_on)
            return OWN_XBUS;
        if (tk.psp_on && idx < ctl_pins)
            return OWN_PSP;
        if (tk.alt_on && idx == alt_idx)
            return OWN_ALT;
        return OWN_GPIO;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++)
                stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++)
                stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
module gpio_regfile
    import gpio_ovr_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic [W-1:0]      pin_sync,
    output logic [W-1:0]      latch_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      rdata
);
    reg_sel_e sel;
    logic     hit_latch;
    logic     hit_dir;

    assign sel       = reg_sel_e'(addr);
    assign hit_latch = wr && (sel == REG_PIN || sel == REG_LATCH);
    assign hit_dir   = wr && (sel == REG_DIR);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '1;
        end else begin
            if (hit_latch)
                latch_q <= wdata;
            if (hit_dir)
                dir_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            REG_PIN:   rdata = pin_sync;
            REG_LATCH: rdata = latch_q;
            REG_DIR:   rdata = dir_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_mux.sv
`timescale 1ns/1ps
module gpio_pin_mux
    import gpio_ovr_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int N_CTL  = CTL_PINS,
    parameter int ALT_AT = ALT_IDX
) (
    input  takeover_t    tk,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] xbus_out,
    input  logic         xbus_oe,
    input  logic         alt_out,
    input  logic         alt_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_owner_e own;
        pad_ctl_t   ctl;

        assign own = owner_of(tk, i, N_CTL, ALT_AT);

        always_comb begin
            unique case (own)
                OWN_XBUS: ctl = '{drive: xbus_oe,   level: xbus_out[i]};
                OWN_PSP:  ctl = '{drive: 1'b0,      level: latch_q[i]};
                OWN_ALT:  ctl = '{drive: alt_oe,    level: alt_out};
                default:  ctl = '{drive: ~dir_q[i], level: latch_q[i]};
            endcase
        end

        assign pad_out[i] = ctl.level;
        assign pad_oe[i]  = ctl.drive;
    end
endmodule

// File: rtl/gpio_in_route.sv
`timescale 1ns/1ps
module gpio_in_route
    import gpio_ovr_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int ALT_AT = ALT_IDX
) (
    input  takeover_t    tk,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] xbus_in,
    output logic         strobe_rd_n,
    output logic         strobe_wr_n,
    output logic         strobe_cs_n,
    output logic         alt_in
);
    logic psp_live;
    logic alt_live;

    assign psp_live = tk.psp_on && !tk.xbus_on;
    assign alt_live = tk.alt_on && !tk.xbus_on;

    assign xbus_in     = tk.xbus_on ? pin_sync : '0;
    assign strobe_rd_n = psp_live ? pin_sync[0] : 1'b1;
    assign strobe_wr_n = psp_live ? pin_sync[1] : 1'b1;
    assign strobe_cs_n = psp_live ? pin_sync[2] : 1'b1;
    assign alt_in      = alt_live ? pin_sync[ALT_AT] : 1'b0;
endmodule

// File: rtl/gpio_port_ovr.sv
`timescale 1ns/1ps
module gpio_port_ovr
    import gpio_ovr_pkg::*;
#(
    parameter int W      = PORT_W,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    input  logic              xbus_disable,
    input  logic [W-1:0]      xbus_ad_out,
    input  logic              xbus_ad_oe,
    output logic [W-1:0]      xbus_ad_in,
    input  logic              psp_mode,
    output logic              psp_rd_n,
    output logic              psp_wr_n,
    output logic              psp_cs_n,
    input  logic              alt_sel_n,
    input  logic              alt_out,
    input  logic              alt_oe,
    output logic              alt_in
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    takeover_t    tk;

    assign tk = '{xbus_on: !xbus_disable, psp_on: psp_mode, alt_on: !alt_sel_n};

    gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_regfile #(.W(W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .pin_sync (pin_sync),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .rdata    (bus_rdata)
    );

    gpio_pin_mux #(.W(W), .N_CTL(CTL_PINS), .ALT_AT(ALT_IDX)) u_mux (
        .tk       (tk),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .xbus_out (xbus_ad_out),
        .xbus_oe  (xbus_ad_oe),
        .alt_out  (alt_out),
        .alt_oe   (alt_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    gpio_in_route #(.W(W), .ALT_AT(ALT_IDX)) u_inr (
        .tk          (tk),
        .pin_sync    (pin_sync),
        .xbus_in     (xbus_ad_in),
        .strobe_rd_n (psp_rd_n),
        .strobe_wr_n (psp_wr_n),
        .strobe_cs_n (psp_cs_n),
        .alt_in      (alt_in)
    );
endmodule

// File: rtl/gpio_port_ovr_chk.sv
`timescale 1ns/1ps
module gpio_port_ovr_chk
    import gpio_ovr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic [7:0]        pad_in,
    input logic [7:0]        pad_out,
    input logic [7:0]        pad_oe,
    input logic              xbus_disable,
    input logic [7:0]        xbus_ad_out,
    input logic              xbus_ad_oe,
    input logic              psp_mode,
    input logic              psp_rd_n,
    input logic              psp_wr_n,
    input logic              psp_cs_n,
    input logic              alt_sel_n,
    input logic              alt_out,
    input logic              alt_oe,
    input logic [7:0]        latch_q,
    input logic [7:0]        dir_q
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dir_q == 8'hFF && latch_q == 8'h00));

    assert_gpio_drive_R2: assert property (@(posedge clk) disable iff (rst)
        (xbus_disable && !psp_mode && alt_sel_n) |-> (pad_oe == ~dir_q));

    assert_port_write_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_PIN) |=> (latch_q == $past(bus_wdata)));

    assert_sync_latency_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && bus_addr == REG_PIN) |-> (bus_rdata == $past(pad_in, 2)));

    assert_xbus_owns_R6: assert property (@(posedge clk) disable iff (rst)
        !xbus_disable |-> (pad_out == xbus_ad_out && pad_oe == {8{xbus_ad_oe}}));

    assert_psp_inputs_R7: assert property (@(posedge clk) disable iff (rst)
        (xbus_disable && psp_mode) |-> (pad_oe[2:0] == 3'b000));

    assert_psp_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !(xbus_disable && psp_mode) |-> ({psp_cs_n, psp_wr_n, psp_rd_n} == 3'b111));

    assert_alt_pin_R8: assert property (@(posedge clk) disable iff (rst)
        (xbus_disable && !alt_sel_n) |-> (pad_oe[7] == alt_oe && pad_out[7] == alt_out));

    assert_unused_addr_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_NONE) |=> ($stable(latch_q) && $stable(dir_q)));
endmodule

bind gpio_port_ovr gpio_port_ovr_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .pad_in       (pad_in),
    .pad_out      (pad_out),
    .pad_oe       (pad_oe),
    .xbus_disable (xbus_disable),
    .xbus_ad_out  (xbus_ad_out),
    .xbus_ad_oe   (xbus_ad_oe),
    .psp_mode     (psp_mode),
    .psp_rd_n     (psp_rd_n),
    .psp_wr_n     (psp_wr_n),
    .psp_cs_n     (psp_cs_n),
    .alt_sel_n    (alt_sel_n),
    .alt_out      (alt_out),
    .alt_oe       (alt_oe),
    .latch_q      (latch_q),
    .dir_q        (dir_q)
);

// File: tb/gpio_port_ovr_tb.sv
`timescale 1ns/1ps
module gpio_port_ovr_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic       xbus_disable = 1'b1;
    logic [7:0] xbus_ad_out = 8'h00;
    logic       xbus_ad_oe = 1'b0;
    logic [7:0] xbus_ad_in;
    logic       psp_mode = 1'b0;
    logic       psp_rd_n, psp_wr_n, psp_cs_n;
    logic       alt_sel_n = 1'b1;
    logic       alt_out = 1'b0;
    logic       alt_oe = 1'b0;
    logic       alt_in;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_port_ovr u_dut (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .xbus_disable(xbus_disable), .xbus_ad_out(xbus_ad_out), .xbus_ad_oe(xbus_ad_oe),
        .xbus_ad_in(xbus_ad_in),
        .psp_mode(psp_mode), .psp_rd_n(psp_rd_n), .psp_wr_n(psp_wr_n), .psp_cs_n(psp_cs_n),
        .alt_sel_n(alt_sel_n), .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] e_oe, e_out, syncv;
        logic       xd, pm, an;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #1;

        // R1: reset state
        reg_read(2'd2, rv); check("R1 dir reset", rv, 8'hFF);
        reg_read(2'd1, rv); check("R1 latch reset", rv, 8'h00);
        check("R1 pad_oe reset", pad_oe, 8'h00);

        // R2: direction sweep against a fixed latch pattern
        reg_write(2'd1, 8'hA5);
        for (int d = 0; d < 256; d++) begin
            reg_write(2'd2, d[7:0]);
            check("R2 pad_oe", pad_oe, ~d[7:0]);
            check("R2 pad_out", pad_out & ~d[7:0], 8'hA5 & ~d[7:0]);
        end

        // R3: latch read returns latch, not pins
        reg_write(2'd2, 8'hFF);
        reg_write(2'd1, 8'h3C);
        pad_in = 8'hC3;
        edges(3);
        reg_read(2'd1, rv); check("R3 latch vs pin", rv, 8'h3C);

        // R4: port-address writes land in the latch
        for (int v = 0; v < 256; v++) begin
            reg_write(2'd0, v[7:0]);
            reg_read(2'd1, rv); check("R4 port write", rv, v[7:0]);
        end
        reg_write(2'd2, 8'h5A);
        reg_read(2'd2, rv); check("R4 dir write", rv, 8'h5A);

        // R5: pin read latency of two edges, mixed directions
        reg_write(2'd2, 8'h0F);
        pad_in = 8'h00;
        edges(3);
        for (int v = 1; v < 256; v++) begin
            @(posedge clk); #1;
            pad_in = v[7:0];
            edges(1);
            reg_read(2'd0, rv); check("R5 one edge", rv, v[7:0] - 8'd1);
            edges(1);
            reg_read(2'd0, rv); check("R5 two edges", rv, v[7:0]);
        end

        // R6/R7/R8: all takeover combinations
        reg_write(2'd2, 8'h96);
        reg_write(2'd1, 8'h3C);
        pad_in = 8'hA6;
        edges(3);
        syncv = 8'hA6;
        for (int m = 0; m < 8; m++) begin
            for (int e = 0; e < 4; e++) begin
                xd = m[0]; pm = m[1]; an = m[2];
                xbus_disable = xd; psp_mode = pm; alt_sel_n = an;
                xbus_ad_out = 8'h5A + 8'(m);
                xbus_ad_oe = e[0];
                alt_oe = e[1];
                alt_out = m[1];
                #1;
                for (int i = 0; i < 8; i++) begin
                    if (!xd) begin
                        e_oe[i] = xbus_ad_oe; e_out[i] = xbus_ad_out[i];
                    end else if (pm && i < 3) begin
                        e_oe[i] = 1'b0; e_out[i] = 1'b0;
                    end else if (!an && i == 7) begin
                        e_oe[i] = alt_oe; e_out[i] = alt_out;
                    end else begin
                        e_oe[i] = ~(8'h96 >> i) & 1'b1; e_out[i] = (8'h3C >> i) & 1'b1;
                    end
                end
                if (!xd)
                    check("R6 pad_oe", pad_oe, e_oe);
                else if (pm)
                    check("R7 pad_oe", pad_oe, e_oe);
                else
                    check("R8 pad_oe", pad_oe, e_oe);
                check("R6 pad_out", pad_out & e_oe, e_out & e_oe);
                check("R6 xbus_ad_in", xbus_ad_in, xd ? 8'h00 : syncv);
                check("R7 strobes", {5'd0, psp_cs_n, psp_wr_n, psp_rd_n},
                      (xd && pm) ? {5'd0, syncv[2:0]} : 8'h07);
                check("R8 alt_in", {7'd0, alt_in}, (xd && !an) ? {7'd0, syncv[7]} : 8'h00);
            end
        end
        xbus_disable = 1'b1; psp_mode = 1'b0; alt_sel_n = 1'b1;
        #1;

        // R9: unused address
        reg_write(2'd3, 8'h55);
        reg_read(2'd1, rv); check("R9 latch kept", rv, 8'h3C);
        reg_read(2'd2, rv); check("R9 dir kept", rv, 8'h96);
        reg_read(2'd3, rv); check("R9 read zero", rv, 8'h00);

        // R10: writes during external-bus ownership are kept
        xbus_disable = 1'b0; xbus_ad_oe = 1'b0; xbus_ad_out = 8'h11;
        reg_write(2'd2, 8'h00);
        reg_write(2'd1, 8'hE7);
        check("R10 still bus-owned", pad_oe, 8'h00);
        xbus_disable = 1'b1;
        #1;
        check("R10 oe after release", pad_oe, 8'hFF);
        check("R10 out after release", pad_out, 8'hE7);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule